// File: doc/BRIEF.md
# Merged Reconstruction and Component-Formation Network

This block is a purely combinational XOR network for subquadratic binary-field multiply-and-add datapaths that keep their running state in component form. A state of M bits (M a power of two, T = log2(M)) is held as a component array of N = 3^T bits. The usual next-state path first reconstructs the M-bit vector from the array and then forms the components of that vector again. This block produces the same N-bit result from one three-way recursion on pairwise XORs of the array's thirds. That recursion takes T XOR levels, where the two-step path takes 2·T. The block builds no intermediate M-bit vector.

A second output gives the inner product (parity of the AND) of one M-bit row with the reconstructed vector. It is computed straight from the component array against an expanded form of the row. The field multiplier and the state register stay outside the block.

Conventions used throughout: an array written [A, B, C] has A in its lowest bits. Component formation of V = [V0, V1] (V0 the low half) is CF(V) = [CF(V1), CF(V0^V1), CF(V0)]. Reconstruction of an array [W0, W1, W2] is RC = [RC(W0)^RC(W1), RC(W1)^RC(W2)]. Both are identity on single bits.

Top module: `rcvf_merge`

## Requirements
- R1: comp_o equals CF(RC(comp_i)) for every comp_i, with CF and RC as defined above.
- R2: With comp_i split into thirds [W0, W1, W2], the thirds of comp_o, lowest first, are g(W1^W2), g(W0^W2), g(W0^W1). Here g is the same function at size M/2, and g is identity at one bit.
- R3: The three thirds of comp_o XOR to all zeros for every input.
- R4: An all-zero comp_i gives an all-zero comp_o and dot_o = 0, whatever row_i is.
- R5: When the three thirds of comp_i are equal, comp_o is all zeros.
- R6: dot_o equals the parity of row_i AND RC(comp_i).
- R7: An all-zero row_i gives dot_o = 0, whatever comp_i is.
- R8: dot_o equals the parity of comp_i AND G(row_i). G is the expansion G([r0, r1]) = [G(r0), G(r0^r1), G(r1)], identity at one bit.
- R9: A comp_i with exactly one bit set gives a comp_o with exactly M bits set.
- R10: Both outputs depend only on the present inputs: a new input is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| comp_i | input | 3**$clog2(M) | Component-form array |
| row_i | input | M | Row for the inner product |
| comp_o | output | 3**$clog2(M) | Merged reconstruct-then-form result |
| dot_o | output | 1 | Row times reconstructed vector, over GF(2) |

## Verification
From the ports it is hard to tell whether the index order inside each recursion level is right. A swapped third or a mirrored half still gives outputs that look plausible, and it still meets linearity checks such as R3 and R4. The bench therefore sweeps every comp_i and every row_i at M = 4 against a reference built from separate reconstruction and formation functions. At M = 8 it checks each output third against a half-size reference on the pairwise XOR (R2). At M = 16 it walks a single set bit through all 81 positions, so that every path of the network is seen on its own.

// File: rtl/rcvf_merge.sv
module rcvf_merge #(
  parameter  int M = 8,
  localparam int T = $clog2(M),
  localparam int N = 3 ** T
) (
  input  logic [N-1:0] comp_i,
  input  logic [M-1:0] row_i,
  output logic [N-1:0] comp_o,
  output logic         dot_o
);

  function automatic int lvl_off(input int k);
    int s;
    int p;
    s = 0;
    p = 1;
    for (int i = 0; i < k; i++) begin
      s += p * (M >> i);
      p *= 3;
    end
    return s;
  endfunction

  localparam int RTOT = lvl_off(T + 1);

  logic [N-1:0] mst [0:T];
  assign mst[0] = comp_i;

  for (genvar l = 0; l < T; l++) begin : g_mlvl
    localparam int B = 3 ** (T - l);
    localparam int S = B / 3;
    for (genvar b = 0; b < N / B; b++) begin : g_blk
      for (genvar j = 0; j < S; j++) begin : g_pos
        localparam int O = b * B + j;
        assign mst[l+1][O]       = mst[l][O+S] ^ mst[l][O+2*S];
        assign mst[l+1][O+S]     = mst[l][O]   ^ mst[l][O+2*S];
        assign mst[l+1][O+2*S]   = mst[l][O]   ^ mst[l][O+S];
      end
    end
  end

  assign comp_o = mst[T];

  logic [RTOT-1:0] rf;
  assign rf[M-1:0] = row_i;

  for (genvar k = 1; k <= T; k++) begin : g_rlvl
    localparam int L   = M >> k;
    localparam int SRC = lvl_off(k - 1);
    localparam int DST = lvl_off(k);
    for (genvar p = 0; p < 3 ** (k - 1); p++) begin : g_vec
      for (genvar j = 0; j < L; j++) begin : g_pos
        assign rf[DST+3*p*L+j]     = rf[SRC+2*p*L+j];
        assign rf[DST+(3*p+1)*L+j] = rf[SRC+2*p*L+j] ^ rf[SRC+2*p*L+L+j];
        assign rf[DST+(3*p+2)*L+j] = rf[SRC+2*p*L+L+j];
      end
    end
  end

  assign dot_o = ^(rf[RTOT-1 -: N] & comp_i);

endmodule

// File: rtl/rcvf_merge_chk.sv
module rcvf_merge_chk #(
  parameter  int M = 8,
  localparam int T = $clog2(M),
  localparam int N = 3 ** T,
  localparam int S = N / 3
) (
  input logic [N-1:0] comp_i,
  input logic [M-1:0] row_i,
  input logic [N-1:0] comp_o,
  input logic         dot_o
);

  always_comb begin
    p_zero_in_r4: assert (comp_i != '0 || (comp_o == '0 && dot_o == 1'b0));
    p_thirds_cancel_r3: assert ((comp_o[S-1:0] ^ comp_o[2*S-1:S] ^ comp_o[N-1:2*S]) == '0);
    p_equal_thirds_r5: assert (!(comp_i[S-1:0] == comp_i[2*S-1:S] &&
                                 comp_i[S-1:0] == comp_i[N-1:2*S]) || comp_o == '0);
    p_row_zero_r7: assert (row_i != '0 || dot_o == 1'b0);
    p_unit_weight_r9: assert ($countones(comp_i) != 1 || $countones(comp_o) == M);
  end

endmodule

bind rcvf_merge rcvf_merge_chk #(.M(M)) u_chk (
  .comp_i(comp_i),
  .row_i (row_i),
  .comp_o(comp_o),
  .dot_o (dot_o)
);

// File: tb/rcvf_merge_tb.sv
module rcvf_merge_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  logic [8:0]  w4 = '0;
  logic [3:0]  r4 = '0;
  logic [8:0]  o4;
  logic        d4;
  logic [26:0] w8 = '0;
  logic [7:0]  r8 = '0;
  logic [26:0] o8;
  logic        d8;
  logic [80:0] w16 = '0;
  logic [15:0] r16 = '0;
  logic [80:0] o16;
  logic        d16;

  rcvf_merge #(.M(4))  u_dut     (.comp_i(w4),  .row_i(r4),  .comp_o(o4),  .dot_o(d4));
  rcvf_merge #(.M(8))  u_dut_m8  (.comp_i(w8),  .row_i(r8),  .comp_o(o8),  .dot_o(d8));
  rcvf_merge #(.M(16)) u_dut_m16 (.comp_i(w16), .row_i(r16), .comp_o(o16), .dot_o(d16));

  function automatic int pow3(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r *= 3;
    return r;
  endfunction

  function automatic logic [15:0] ref_rc(input logic [80:0] w, input int t);
    logic [15:0] res = '0;
    for (int k = 0; k < (1 << t); k++) begin
      logic acc = 1'b0;
      for (int i = 0; i < pow3(t); i++) begin
        int x = i;
        logic ok = 1'b1;
        for (int lv = 0; lv < t; lv++) begin
          int d = x % 3;
          int b = (k >> lv) & 1;
          if (d != b && d != b + 1) ok = 1'b0;
          x = x / 3;
        end
        acc ^= ok & w[i];
      end
      res[k] = acc;
    end
    return res;
  endfunction

  function automatic logic [80:0] ref_form(input logic [15:0] v, input int t, input bit mirror);
    logic [80:0] res = '0;
    for (int i = 0; i < pow3(t); i++) begin
      logic [15:0] e [16];
      logic [15:0] ne [16];
      int len = 1 << t;
      for (int j = 0; j < 16; j++) e[j] = 16'(1) << j;
      for (int lv = t - 1; lv >= 0; lv--) begin
        int d = (i / pow3(lv)) % 3;
        int h = len / 2;
        if (mirror) d = 2 - d;
        for (int j = 0; j < h; j++)
          ne[j] = (d == 0) ? e[h+j] : (d == 1) ? (e[j] ^ e[h+j]) : e[j];
        for (int j = 0; j < h; j++) e[j] = ne[j];
        len = h;
      end
      res[i] = ^(v & e[0]);
    end
    return res;
  endfunction

  function automatic logic [80:0] ref_merge(input logic [80:0] w, input int t);
    return ref_form(ref_rc(w, t), t, 1'b0);
  endfunction

  task automatic chk(input string req, input logic [80:0] act, input logic [80:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    r4 = 4'hF; r8 = 8'hA5; r16 = 16'h1234;
    repeat (3) @(negedge clk);
    chk("R4 reset m4 comp", 81'(o4), '0);
    chk("R4 reset m4 dot", 81'(d4), '0);
    chk("R4 reset m16 comp", o16, '0);
    chk("R4 reset m16 dot", 81'(d16), '0);
    rst_n = 1'b1;

    // R1 R6 R7 R8: exhaustive at M=4
    for (int w = 0; w < 512; w++) begin
      for (int r = 0; r < 16; r++) begin
        @(posedge clk);
        w4 = 9'(w); r4 = 4'(r);
        @(negedge clk);
        if (r == 0) begin
          chk("R1 m4 merged", 81'(o4), ref_merge(81'(w), 2) & 81'h1FF);
          chk("R7 m4 zero row", 81'(d4), '0);
        end
        chk("R6 m4 dot", 81'(d4), 81'(^(4'(r) & ref_rc(81'(w), 2))));
        chk("R8 m4 dot expanded", 81'(d4), 81'(^(9'(w) & 9'(ref_form(16'(r), 2, 1'b1)))));
      end
    end

    // R10: input change reflected without a clock edge
    @(negedge clk);
    w4 = 9'h001; r4 = 4'h1;
    #1;
    chk("R10 m4 no clock", 81'(o4), ref_merge(81'h001, 2) & 81'h1FF);

    // R2 R3 R5 R1 R6: random at M=8
    for (int n = 0; n < 300; n++) begin
      logic [26:0] w;
      logic [8:0]  t0, t1, t2;
      @(posedge clk);
      w = 27'({$urandom, $urandom});
      if (n % 10 == 0) w = {w[8:0], w[8:0], w[8:0]};
      w8 = w; r8 = 8'($urandom);
      @(negedge clk);
      t0 = w[8:0]; t1 = w[17:9]; t2 = w[26:18];
      chk("R1 m8 merged", 81'(o8), ref_merge(81'(w), 3) & 81'h7FFFFFF);
      chk("R2 m8 third0", 81'(o8[8:0]),   ref_merge(81'(t1 ^ t2), 2) & 81'h1FF);
      chk("R2 m8 third1", 81'(o8[17:9]),  ref_merge(81'(t0 ^ t2), 2) & 81'h1FF);
      chk("R2 m8 third2", 81'(o8[26:18]), ref_merge(81'(t0 ^ t1), 2) & 81'h1FF);
      chk("R3 m8 thirds cancel", 81'(o8[8:0] ^ o8[17:9] ^ o8[26:18]), '0);
      if (t0 == t1 && t1 == t2) chk("R5 m8 equal thirds", 81'(o8), '0);
      chk("R6 m8 dot", 81'(d8), 81'(^(r8 & 8'(ref_rc(81'(w), 3)))));
    end

    // R9 R1: one-hot walk at M=16
    for (int p = 0; p < 81; p++) begin
      @(posedge clk);
      w16 = 81'(1) << p; r16 = 16'($urandom);
      @(negedge clk);
      chk("R9 m16 unit weight", 81'($countones(o16)), 81'd16);
      chk("R1 m16 merged", o16, ref_merge(w16, 4));
      chk("R8 m16 dot", 81'(d16), 81'(^(w16 & ref_form(r16, 4, 1'b1))));
    end

    // R1 R6 R7 R4: random and corner inputs at M=16
    for (int n = 0; n < 200; n++) begin
      logic [80:0] w;
      @(posedge clk);
      w = 81'({$urandom, $urandom, $urandom});
      if (n == 0) w = '0;
      if (n == 1) w = '1;
      w16 = w; r16 = (n == 2) ? 16'h0 : 16'($urandom);
      @(negedge clk);
      chk("R1 m16 merged", o16, ref_merge(w, 4));
      chk("R6 m16 dot", 81'(d16), 81'(^(r16 & ref_rc(w, 4))));
      if (n == 0) chk("R4 m16 zero comp", o16, '0);
      if (n == 2) chk("R7 m16 zero row", 81'(d16), '0);
    end

    step();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule